// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block gathers eight interrupt inputs, ranks them by a fixed priority and raises one interrupt line toward a processor. Software talks to it over a byte-wide port with two addresses: a command address (`addr` = 0) and a data address (`addr` = 1). An initialization sequence sets the vector base, a cascade descriptor and the end-of-interrupt mode. After that, the data address carries the mask and the command address carries end-of-interrupt and read-select commands.

When the processor pulses the acknowledge strobe, the controller picks the winning input and moves it from the request register to the in-service register. In automatic end-of-interrupt mode the in-service bit is not set. The vector for input n is the base plus n. If no eligible request exists at acknowledge time, the controller returns a spurious vector. The cascade descriptor is stored and driven on an output so that surrounding logic can use it. No second controller is modelled.

Top module: `vec_intc`

## Requirements
- R1: After reset the request and in-service registers are zero, the mask is 0xFF, command-address reads return the request register, and `intOut` is low.
- R2: Writing 0x11 to the command address starts initialization. The next three data-address writes load, in order, the vector base, the cascade descriptor (reported on `cascadeCfg`) and the mode word.
- R3: One cycle after an acknowledge that grants input n, `vecOut` holds base + n.
- R4: Outside initialization, a data-address write loads the mask, and data-address reads return it. A mask bit of 1 keeps its input from raising `intOut`.
- R5: Priority is fixed, with input 0 highest. `intOut` is high only when an unmasked request ranks above every in-service bit.
- R6: In normal mode (mode word 0x01) an acknowledge sets the in-service bit of the winner and clears its request bit.
- R7: In automatic mode (mode word 0x03, bit 1 set) an acknowledge clears the winner's request bit and leaves the in-service register unchanged.
- R8: Writing 0x60+n to the command address clears in-service bit n and no other bit.
- R9: Writing 0x0B to the command address makes later command-address reads return the in-service register. Writing 0x0A returns them to the request register.
- R10: An acknowledge with no eligible request returns base + 7 and changes neither the in-service register nor the request register.
- R11: A rising edge on an input latches its request bit. An input held high does not latch again after its request is acknowledged.
- R12: Writing 0x11 clears the request and in-service registers, sets the mask to 0xFF and selects request-register reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational, selected by `addr`) |
| irqIn | input | 8 | Interrupt request inputs, bit 0 highest priority |
| ackStb | input | 1 | Interrupt acknowledge strobe, one cycle |
| intOut | output | 1 | Interrupt output to the processor |
| vecOut | output | 8 | Vector captured on acknowledge |
| cascadeCfg | output | 8 | Stored cascade descriptor |

## Verification
Register writes take effect at the clock edge on which they are presented. Reads are combinational, so the bench samples them at the falling edge after the write. A rising input edge is latched at the next clock edge, which makes `intOut` valid at the following falling edge. The vector is registered at the acknowledge edge, and a monitor compares it at the falling edge that follows. Every check is made at a falling edge, once all registers on the path have been updated.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] CMD_INIT   = 8'h11;
  localparam logic [7:0] CMD_RD_ISR = 8'h0B;
  localparam logic [7:0] CMD_RD_IRR = 8'h0A;
  localparam logic [4:0] CMD_EOI_HI = 5'b01100;

  typedef struct packed {
    logic       initClr;
    logic       loadBase;
    logic       loadCasc;
    logic       loadMode;
    logic       loadMask;
    logic       eoi;
    logic [2:0] eoiIdx;
    logic       selIsr;
    logic       selIrr;
  } vicStrobes_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        addr,
  input  logic [7:0]  wrData,
  output vicStrobes_t strb
);
  typedef enum logic [1:0] {S_RUN, S_W2, S_W3, S_W4} seqState_t;
  seqState_t state, stateNxt;

  always_comb begin
    strb = '0;
    stateNxt = state;
    if (wrEn) begin
      if (!addr) begin
        if (wrData == CMD_INIT) begin
          strb.initClr = 1'b1;
          stateNxt = S_W2;
        end else if (state == S_RUN) begin
          if (wrData[7:3] == CMD_EOI_HI) begin
            strb.eoi = 1'b1;
            strb.eoiIdx = wrData[2:0];
          end
          if (wrData == CMD_RD_ISR) strb.selIsr = 1'b1;
          if (wrData == CMD_RD_IRR) strb.selIrr = 1'b1;
        end
      end else begin
        case (state)
          S_W2: begin strb.loadBase = 1'b1; stateNxt = S_W3; end
          S_W3: begin strb.loadCasc = 1'b1; stateNxt = S_W4; end
          S_W4: begin strb.loadMode = 1'b1; stateNxt = S_RUN; end
          default: strb.loadMask = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_RUN;
    else       state <= stateNxt;
  end

  // R2
  init_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.initClr |=> (state == S_W2));

  // R2
  seq_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCasc && !strb.initClr) |=> (state == S_W4));
endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vicStrobes_t       strb,
  input  logic [7:0]        wrData,
  input  logic              addr,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              ackStb,
  output logic [7:0]        rdData,
  output logic              intOut,
  output logic [7:0]        vecOut,
  output logic [7:0]        cascadeCfg
);
  localparam int IDX_W = $clog2(NUM_IN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IN - 1);

  logic [NUM_IN-1:0] irr, isr, mask, irqPrev, rise, pend, ackClr, ackSet, eoiClr;
  logic [7:0] baseReg, cascReg;
  logic aeoiMode, readIsr;
  logic winVld, isrVld, grant;
  logic [IDX_W-1:0] winIdx, isrIdx;

  assign rise = irqIn & ~irqPrev;
  assign pend = irr & ~mask;

  always_comb begin
    winVld = 1'b0; winIdx = '0;
    isrVld = 1'b0; isrIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i]) begin winVld = 1'b1; winIdx = IDX_W'(i); end
      if (isr[i])  begin isrVld = 1'b1; isrIdx = IDX_W'(i); end
    end
  end

  assign grant  = winVld && (!isrVld || (winIdx < isrIdx));
  assign intOut = grant;
  assign ackClr = (ackStb && grant) ? (NUM_IN'(1) << winIdx) : '0;
  assign ackSet = aeoiMode ? '0 : ackClr;
  assign eoiClr = strb.eoi ? (NUM_IN'(1) << strb.eoiIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.initClr) begin
      irr     <= '0;
      isr     <= '0;
      mask    <= '1;
      readIsr <= 1'b0;
    end else begin
      irr <= (irr & ~ackClr) | rise;
      isr <= (isr & ~eoiClr) | ackSet;
      if (strb.loadMask) mask <= wrData[NUM_IN-1:0];
      if (strb.selIsr) readIsr <= 1'b1;
      else if (strb.selIrr) readIsr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      cascReg  <= '0;
      aeoiMode <= 1'b0;
      vecOut   <= '0;
    end else begin
      if (strb.loadBase) baseReg <= wrData;
      if (strb.loadCasc) cascReg <= wrData;
      if (strb.loadMode) aeoiMode <= wrData[1];
      if (ackStb) vecOut <= baseReg + 8'(grant ? winIdx : LAST_IDX);
    end
  end

  assign cascadeCfg = cascReg;
  assign rdData = addr ? 8'(mask) : 8'(readIsr ? isr : irr);

  // R6
  isr_gain_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(isr & ~$past(isr))) |-> ($past(ackStb) && !$past(aeoiMode)));

  // R7
  aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && aeoiMode) |=> ((isr & ~$past(isr)) == '0));

  // R8
  eoi_single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !ackStb) |=> ($countones(isr ^ $past(isr)) <= 1));

  // R12
  init_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.initClr |=> ((mask == '1) && (isr == '0) && (irr == '0)));

  // R5
  int_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((pend != '0) && !isr[0]));

  // R10
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && !intOut && !strb.eoi && !strb.initClr) |=>
      ((vecOut == $past(baseReg) + 8'(NUM_IN - 1)) && (isr == $past(isr))));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] irqIn,
  input  logic       ackStb,
  output logic       intOut,
  output logic [7:0] vecOut,
  output logic [7:0] cascadeCfg
);
  vicStrobes_t strb;

  vic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .strb(strb)
  );

  vic_dp #(.NUM_IN(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .addr(addr),
    .irqIn(irqIn), .ackStb(ackStb), .rdData(rdData), .intOut(intOut),
    .vecOut(vecOut), .cascadeCfg(cascadeCfg)
  );
endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, wrEn, addr, ackStb, intOut;
  logic [7:0] wrData, rdData, irqIn, vecOut, cascadeCfg;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_intc u_vec_intc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .ackStb(ackStb), .intOut(intOut),
    .vecOut(vecOut), .cascadeCfg(cascadeCfg)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic a, input logic [7:0] exp, input string tag);
    addr = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk); irqIn = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] expVec, input string tag);
    @(negedge clk); ackStb = 1'b1;
    expQ.push_back(expVec); tagQ.push_back(tag);
    @(negedge clk); ackStb = 1'b0;
  endtask

  // Monitor: compares vector one edge after the acknowledge
  initial begin
    forever begin
      @(posedge clk);
      if (ackStb === 1'b1) begin
        @(negedge clk);
        if (expQ.size() == 0) chk("R3 unexpected ack", vecOut, 8'hxx);
        else chk(tagQ.pop_front(), vecOut, expQ.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = 1'b0; wrData = '0; irqIn = '0; ackStb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rdChk(1'b0, 8'h00, "R1 irr after reset");
    rdChk(1'b1, 8'hFF, "R1 mask after reset");
    chk("R1 intOut after reset", {7'b0, intOut}, 8'h00);

    // Init: base 0x30, master cascade 0x04, normal EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h30); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R2 cascade stored", cascadeCfg, 8'h04);
    rdChk(1'b1, 8'hFF, "R12 mask after init");
    wr(1'b1, 8'h00);
    rdChk(1'b1, 8'h00, "R4 mask loaded");

    setIrq(8'h08);
    chk("R11 edge raises intOut", {7'b0, intOut}, 8'h01);
    rdChk(1'b0, 8'h08, "R9 irr read");
    ack(8'h33, "R3 vector input3");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h08, "R6 isr set on ack");
    wr(1'b0, 8'h0A);
    rdChk(1'b0, 8'h00, "R6 irr cleared on ack");

    setIrq(8'h28);
    chk("R5 lower priority blocked", {7'b0, intOut}, 8'h00);
    setIrq(8'h2A);
    chk("R5 higher priority raises", {7'b0, intOut}, 8'h01);
    ack(8'h31, "R5 vector input1 wins");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h0A, "R6 nested isr");
    wr(1'b0, 8'h61);
    rdChk(1'b0, 8'h08, "R8 eoi clears bit1 only");
    chk("R5 input5 still below isr3", {7'b0, intOut}, 8'h00);
    wr(1'b0, 8'h63);
    rdChk(1'b0, 8'h00, "R8 eoi clears bit3");
    chk("R5 input5 now raises", {7'b0, intOut}, 8'h01);
    ack(8'h35, "R3 vector input5");
    wr(1'b0, 8'h65);
    wr(1'b0, 8'h0A);
    rdChk(1'b0, 8'h00, "R11 held level not relatched");

    setIrq(8'h00);
    wr(1'b1, 8'h04);
    setIrq(8'h04);
    chk("R4 masked input no int", {7'b0, intOut}, 8'h00);
    rdChk(1'b0, 8'h04, "R4 masked request latched");
    ack(8'h37, "R10 spurious vector");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h00, "R10 isr unchanged");
    wr(1'b0, 8'h0A);
    rdChk(1'b0, 8'h04, "R10 irr unchanged");
    wr(1'b1, 8'h00);
    chk("R4 unmask raises", {7'b0, intOut}, 8'h01);
    ack(8'h32, "R3 vector input2");
    wr(1'b0, 8'h62);

    // Re-init with pending request, then automatic EOI
    setIrq(8'h00);
    setIrq(8'h40);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h11);
    rdChk(1'b0, 8'h00, "R12 irr cleared and irr selected");
    rdChk(1'b1, 8'hFF, "R12 mask set");
    wr(1'b1, 8'h48); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
    chk("R2 cascade reported", cascadeCfg, 8'h02);
    wr(1'b1, 8'h00);
    setIrq(8'h50);
    chk("R7 raise in auto mode", {7'b0, intOut}, 8'h01);
    ack(8'h4C, "R7 vector base 0x48 input4");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h00, "R7 no isr in auto mode");
    chk("R7 no int after ack", {7'b0, intOut}, 8'h00);

    repeat (2) @(negedge clk);
    chk("R3 all vectors seen", 8'(expQ.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule